// File: doc/BRIEF.md
# Cache Write-Policy and Uncached-Window Controller

This block sits beside a cache data array and decides, for every CPU access, whether the array, main memory, or both are written. Tag lookup and victim selection happen elsewhere. The block receives their results as a hit flag, a line index and an eviction request. It drives the array's write strobe and a single request/acknowledge memory port, and it reports completion to the CPU with a one-cycle `cpu_done` pulse. The CPU holds its request steady until that pulse.

Three hit-write policies are selected by `mode`:
- `0` is write-through.
- `1` is posted write through a one-entry buffer.
- `2` is write-back with one dirty flag per line.
- `3` behaves as `0`.

A base/size register pair marks the half-open range `[base, base+size)` as uncacheable. Accesses there bypass the array completely. The policy should only be changed while `quiescent` is high.

The sequencer has four states: `ST_IDLE`, `ST_CPU_WR`, `ST_CPU_RD` and `ST_EVICT`. Its transitions are:
- The write launch (`ST_IDLE`→`ST_CPU_WR`) handles a miss, an uncached write or a write-through hit.
- The read launch (`ST_IDLE`→`ST_CPU_RD`) handles an uncached read.
- The writeback launch (`ST_IDLE`→`ST_EVICT`) handles a dirty victim.
- The acknowledge return goes from any memory state back to `ST_IDLE` on `mem_ack`.

The posted buffer has its own empty/full state. It drains through the memory port whenever it is full. A launch, or a dirty eviction, waits in `ST_IDLE` while the buffer is occupied.

Top module: `wpol_ctrl`

## Requirements
- R1: After reset the block is idle:
  - `mem_req` and `cpu_done` are 0.
  - `dirty_mask` is all zero.
  - `quiescent` is 1.
  - The window is empty, because its size resets to 0.
- R2: Window registers are written when `cfg_we` is high.
  - `cfg_sel`=0 loads the base and `cfg_sel`=1 loads the size.
  - An address A is uncacheable when base ≤ A and A−base < size. The address base+size is therefore cacheable.
  - A size of 0 makes every address cacheable.
- R3: An uncacheable read or write never asserts `cache_we` and never marks a line dirty, even when `lookup_hit` is 1.
  - The access goes to memory.
  - `cpu_done` pulses in the cycle of `mem_ack`.
  - For a read, `cpu_rdata` equals `mem_rdata` and `cpu_rd_from_array` is 0.
- R4: A cacheable write with `lookup_hit`=0 writes memory only, with no `cache_we`. It completes in the `mem_ack` cycle.
- R5: Write-through hit: `cache_we` pulses in the accepting cycle, then one memory write of the same address and data is made. `cpu_done` pulses in the `mem_ack` cycle. `mem_addr` and `mem_wdata` hold steady while `mem_req` waits for `mem_ack`.
- R6: Posted hit with the buffer empty: `cache_we` and `cpu_done` pulse in the request's first cycle. The data later reaches memory with no CPU wait.
- R7: A posted hit that arrives while the buffer is full is stalled. It is accepted in the cycle after the drain's `mem_ack`.
- R8: A cacheable read whose address equals the occupied buffer's address completes in its first cycle with the buffered data and `cpu_rd_from_array`=0.
- R9: Write-back hit: `cache_we` and `cpu_done` pulse in the first cycle, the line's `dirty_mask` bit is set, and memory is not written.
- R10: Eviction of a dirty line writes `evict_addr`/`evict_data` to memory, pulses `evict_done` on `mem_ack`, and clears the bit. Eviction of a clean line pulses `evict_done` in the first cycle with no memory write.
- R11: No CPU memory access or writeback starts while the buffer is occupied. Memory sees the buffered write before the later access.
- R12: `quiescent` is 1 exactly when the block is idle, the buffer is empty and no line is dirty.
- R13: A cacheable read that does not match the buffer completes in its first cycle with `cpu_rd_from_array`=1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| mode | input | 2 | Policy: 0 through, 1 posted, 2 back, 3 as 0 |
| cfg_we | input | 1 | Window register write strobe |
| cfg_sel | input | 1 | 0 base, 1 size |
| cfg_wdata | input | AW | Window register value |
| req_valid | input | 1 | CPU request, held until `cpu_done` |
| req_write | input | 1 | 1 write, 0 read |
| req_addr | input | AW | Request word address |
| req_wdata | input | DW | Write data |
| lookup_hit | input | 1 | Tag lookup hit for `req_addr` |
| lookup_line | input | LW | Line index of the hit |
| cpu_done | output | 1 | Request completion pulse |
| cpu_rdata | output | DW | Read data from memory or buffer |
| cpu_rd_from_array | output | 1 | Read data is to be taken from the array |
| cache_we | output | 1 | Array write strobe |
| cache_line | output | LW | Array line to write |
| cache_wdata | output | DW | Array write data |
| evict_req | input | 1 | Victim eviction request, held until `evict_done` |
| evict_line | input | LW | Victim line index |
| evict_addr | input | AW | Victim memory address |
| evict_data | input | DW | Victim contents |
| evict_done | output | 1 | Eviction completion pulse |
| mem_req | output | 1 | Memory request |
| mem_we | output | 1 | Memory write enable |
| mem_addr | output | AW | Memory address |
| mem_wdata | output | DW | Memory write data |
| mem_ack | input | 1 | Memory completion |
| mem_rdata | input | DW | Memory read data |
| dirty_mask | output | LINES | Per-line dirty flags |
| quiescent | output | 1 | Safe point for a policy change |

## Verification
Zero-latency results have a due cycle equal to the request's first cycle:
- posted and write-back hits
- cacheable reads
- buffer forwarding
- clean evictions

All other results are due in the cycle of `mem_ack`. The bench memory acknowledges in the third cycle of a request, so a memory-bound operation finishes three cycles after acceptance. A stall adds the drain's remaining cycles on top of that.

The bench drives at the falling edge and samples the combinational completion signals just after it. It counts how many falling edges pass before completion and compares that count to the expected latency. Memory-side and array-side effects are sampled only after enough idle cycles for any posted drain to finish.

// File: rtl/wpol_pkg.sv
package wpol_pkg;

    typedef enum logic [1:0] {
        POL_THRU   = 2'd0,
        POL_POSTED = 2'd1,
        POL_BACK   = 2'd2,
        POL_RSVD   = 2'd3
    } wpol_mode_e;

    typedef enum logic [1:0] {
        ST_IDLE   = 2'd0,
        ST_CPU_WR = 2'd1,
        ST_CPU_RD = 2'd2,
        ST_EVICT  = 2'd3
    } wpol_state_e;

endpackage

// File: rtl/wpol_window.sv
module wpol_window #(
    parameter int AW = 16
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          cfg_we,
    input  logic          cfg_sel,
    input  logic [AW-1:0] cfg_wdata,
    input  logic [AW-1:0] probe_addr,
    output logic          uncached
);
    logic [AW-1:0] base_q;
    logic [AW-1:0] size_q;
    logic [AW-1:0] offset;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            base_q <= '0;
            size_q <= '0;
        end else if (cfg_we) begin
            if (cfg_sel) size_q <= cfg_wdata;
            else         base_q <= cfg_wdata;
        end
    end

    // Offset within the window; a half-open compare keeps base+size outside.
    assign offset   = probe_addr - base_q;
    assign uncached = (probe_addr >= base_q) && (offset < size_q);

endmodule

// File: rtl/wpol_postbuf.sv
module wpol_postbuf #(
    parameter int AW = 16,
    parameter int DW = 16
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          load,
    input  logic [AW-1:0] load_addr,
    input  logic [DW-1:0] load_data,
    input  logic          drain_ack,
    output logic          full,
    output logic [AW-1:0] buf_addr,
    output logic [DW-1:0] buf_data
);
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            full     <= 1'b0;
            buf_addr <= '0;
            buf_data <= '0;
        end else if (load) begin
            full     <= 1'b1;
            buf_addr <= load_addr;
            buf_data <= load_data;
        end else if (drain_ack) begin
            full     <= 1'b0;
        end
    end

    // R7
    postbuf_no_overrun_chk: assert property (@(posedge clk) disable iff (!rst_n)
        load |-> !full);

    // R6
    postbuf_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (full && !drain_ack) |=> (full && $stable(buf_addr) && $stable(buf_data)));

endmodule

// File: rtl/wpol_dirty.sv
module wpol_dirty #(
    parameter int LINES = 8,
    parameter int LW    = $clog2(LINES)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             set,
    input  logic [LW-1:0]    set_line,
    input  logic             clr,
    input  logic [LW-1:0]    clr_line,
    output logic [LINES-1:0] mask
);
    for (genvar g = 0; g < LINES; g++) begin : g_line
        always_ff @(posedge clk) begin
            if (!rst_n)
                mask[g] <= 1'b0;
            else if (set && (set_line == LW'(g)))
                mask[g] <= 1'b1;
            else if (clr && (clr_line == LW'(g)))
                mask[g] <= 1'b0;
        end
    end

endmodule

// File: rtl/wpol_ctrl.sv
module wpol_ctrl
    import wpol_pkg::*;
#(
    parameter int AW    = 16,
    parameter int DW    = 16,
    parameter int LINES = 8,
    localparam int LW   = $clog2(LINES)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [1:0]       mode,
    input  logic             cfg_we,
    input  logic             cfg_sel,
    input  logic [AW-1:0]    cfg_wdata,
    input  logic             req_valid,
    input  logic             req_write,
    input  logic [AW-1:0]    req_addr,
    input  logic [DW-1:0]    req_wdata,
    input  logic             lookup_hit,
    input  logic [LW-1:0]    lookup_line,
    output logic             cpu_done,
    output logic [DW-1:0]    cpu_rdata,
    output logic             cpu_rd_from_array,
    output logic             cache_we,
    output logic [LW-1:0]    cache_line,
    output logic [DW-1:0]    cache_wdata,
    input  logic             evict_req,
    input  logic [LW-1:0]    evict_line,
    input  logic [AW-1:0]    evict_addr,
    input  logic [DW-1:0]    evict_data,
    output logic             evict_done,
    output logic             mem_req,
    output logic             mem_we,
    output logic [AW-1:0]    mem_addr,
    output logic [DW-1:0]    mem_wdata,
    input  logic             mem_ack,
    input  logic [DW-1:0]    mem_rdata,
    output logic [LINES-1:0] dirty_mask,
    output logic             quiescent
);
    wpol_state_e   state_q, state_d;
    wpol_mode_e    pol;
    logic [AW-1:0] op_addr_q;
    logic [DW-1:0] op_data_q;
    logic [LW-1:0] op_line_q;

    logic          uncached;
    logic          buf_full, buf_load, buf_drain;
    logic [AW-1:0] buf_addr;
    logic [DW-1:0] buf_data;
    logic          buf_match;
    logic          dirty_set, dirty_clr;
    logic          victim_dirty;

    assign pol = wpol_mode_e'(mode);

    wpol_window #(.AW(AW)) u_window (
        .clk        (clk),
        .rst_n      (rst_n),
        .cfg_we     (cfg_we),
        .cfg_sel    (cfg_sel),
        .cfg_wdata  (cfg_wdata),
        .probe_addr (req_addr),
        .uncached   (uncached)
    );

    wpol_postbuf #(.AW(AW), .DW(DW)) u_postbuf (
        .clk       (clk),
        .rst_n     (rst_n),
        .load      (buf_load),
        .load_addr (req_addr),
        .load_data (req_wdata),
        .drain_ack (buf_drain),
        .full      (buf_full),
        .buf_addr  (buf_addr),
        .buf_data  (buf_data)
    );

    wpol_dirty #(.LINES(LINES), .LW(LW)) u_dirty (
        .clk      (clk),
        .rst_n    (rst_n),
        .set      (dirty_set),
        .set_line (lookup_line),
        .clr      (dirty_clr),
        .clr_line (op_line_q),
        .mask     (dirty_mask)
    );

    assign buf_match    = buf_full && (buf_addr == req_addr);
    assign victim_dirty = dirty_mask[evict_line];
    assign buf_drain    = buf_full && mem_ack;
    assign quiescent    = (state_q == ST_IDLE) && !buf_full && (dirty_mask == '0);

    // State register
    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    // Operand capture while idle
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            op_addr_q <= '0;
            op_data_q <= '0;
            op_line_q <= '0;
        end else if (state_q == ST_IDLE) begin
            op_addr_q <= evict_req ? evict_addr : req_addr;
            op_data_q <= evict_req ? evict_data : req_wdata;
            op_line_q <= evict_line;
        end
    end

    // Next state and outputs
    always_comb begin
        state_d           = state_q;
        cpu_done          = 1'b0;
        cpu_rdata         = '0;
        cpu_rd_from_array = 1'b0;
        cache_we          = 1'b0;
        cache_line        = lookup_line;
        cache_wdata       = req_wdata;
        evict_done        = 1'b0;
        mem_req           = 1'b0;
        mem_we            = 1'b0;
        mem_addr          = op_addr_q;
        mem_wdata         = op_data_q;
        buf_load          = 1'b0;
        dirty_set         = 1'b0;
        dirty_clr         = 1'b0;

        unique case (state_q)
            ST_IDLE: begin
                if (evict_req) begin
                    if (!victim_dirty)  evict_done = 1'b1;
                    else if (!buf_full) state_d    = ST_EVICT;
                end else if (req_valid) begin
                    if (!req_write) begin
                        if (uncached) begin
                            if (!buf_full) state_d = ST_CPU_RD;
                        end else if (buf_match) begin
                            cpu_done  = 1'b1;
                            cpu_rdata = buf_data;
                        end else begin
                            cpu_done          = 1'b1;
                            cpu_rd_from_array = 1'b1;
                        end
                    end else if (uncached || !lookup_hit) begin
                        if (!buf_full) state_d = ST_CPU_WR;
                    end else if (pol == POL_BACK) begin
                        cache_we  = 1'b1;
                        dirty_set = 1'b1;
                        cpu_done  = 1'b1;
                    end else if (pol == POL_POSTED) begin
                        if (!buf_full) begin
                            cache_we = 1'b1;
                            buf_load = 1'b1;
                            cpu_done = 1'b1;
                        end
                    end else begin
                        if (!buf_full) begin
                            cache_we = 1'b1;
                            state_d  = ST_CPU_WR;
                        end
                    end
                end
            end
            ST_CPU_WR: begin
                mem_req = 1'b1;
                mem_we  = 1'b1;
                if (mem_ack) begin
                    cpu_done = 1'b1;
                    state_d  = ST_IDLE;
                end
            end
            ST_CPU_RD: begin
                mem_req = 1'b1;
                if (mem_ack) begin
                    cpu_done  = 1'b1;
                    cpu_rdata = mem_rdata;
                    state_d   = ST_IDLE;
                end
            end
            ST_EVICT: begin
                mem_req = 1'b1;
                mem_we  = 1'b1;
                if (mem_ack) begin
                    evict_done = 1'b1;
                    dirty_clr  = 1'b1;
                    state_d    = ST_IDLE;
                end
            end
        endcase

        // The posted buffer owns the port while occupied.
        if (buf_full) begin
            mem_req   = 1'b1;
            mem_we    = 1'b1;
            mem_addr  = buf_addr;
            mem_wdata = buf_data;
        end
    end

    // R3
    uncached_no_array_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && uncached && !evict_req) |-> !cache_we);

    // R11
    busy_buf_empty_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q != ST_IDLE) |-> !buf_full);

    // R9
    back_hit_dirty_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (cache_we && pol == POL_BACK) |=> dirty_mask[$past(lookup_line)]);

    // R5
    mem_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req && !mem_ack) |=> (mem_req && $stable(mem_addr) && $stable(mem_wdata)));

endmodule

// File: tb/test_wpol_ctrl.sv
`timescale 1ns/1ps
module test_wpol_ctrl;
    localparam int AW = 16;
    localparam int DW = 16;
    localparam int LINES = 8;
    localparam int LW = 3;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    always #2 clk = ~clk;

    logic [1:0]       mode = '0;
    logic             cfg_we = 1'b0, cfg_sel = 1'b0;
    logic [AW-1:0]    cfg_wdata = '0;
    logic             req_valid = 1'b0, req_write = 1'b0;
    logic [AW-1:0]    req_addr = '0;
    logic [DW-1:0]    req_wdata = '0;
    logic             lookup_hit = 1'b0;
    logic [LW-1:0]    lookup_line = '0;
    logic             cpu_done, cpu_rd_from_array, cache_we, evict_done;
    logic [DW-1:0]    cpu_rdata, cache_wdata, mem_wdata, mem_rdata;
    logic [LW-1:0]    cache_line;
    logic             evict_req = 1'b0;
    logic [LW-1:0]    evict_line = '0;
    logic [AW-1:0]    evict_addr = '0, mem_addr;
    logic [DW-1:0]    evict_data = '0;
    logic             mem_req, mem_we, mem_ack, quiescent;
    logic [LINES-1:0] dirty_mask;

    wpol_ctrl #(.AW(AW), .DW(DW), .LINES(LINES)) i_wpol_ctrl (
        .clk(clk), .rst_n(rst_n), .mode(mode),
        .cfg_we(cfg_we), .cfg_sel(cfg_sel), .cfg_wdata(cfg_wdata),
        .req_valid(req_valid), .req_write(req_write), .req_addr(req_addr),
        .req_wdata(req_wdata), .lookup_hit(lookup_hit), .lookup_line(lookup_line),
        .cpu_done(cpu_done), .cpu_rdata(cpu_rdata), .cpu_rd_from_array(cpu_rd_from_array),
        .cache_we(cache_we), .cache_line(cache_line), .cache_wdata(cache_wdata),
        .evict_req(evict_req), .evict_line(evict_line), .evict_addr(evict_addr),
        .evict_data(evict_data), .evict_done(evict_done),
        .mem_req(mem_req), .mem_we(mem_we), .mem_addr(mem_addr), .mem_wdata(mem_wdata),
        .mem_ack(mem_ack), .mem_rdata(mem_rdata),
        .dirty_mask(dirty_mask), .quiescent(quiescent)
    );

    // Memory model: acknowledges in the third cycle of a request.
    logic [DW-1:0] bmem [16];
    logic [1:0]    mcnt;
    int            wr_cnt, cache_cnt;
    logic [AW-1:0] last_wa;
    logic [DW-1:0] last_wd, last_cd;
    logic [LW-1:0] last_cl;

    assign mem_ack   = mem_req && (mcnt == 2'd2);
    assign mem_rdata = bmem[mem_addr[3:0]];

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            mcnt      <= '0;
            wr_cnt    <= 0;
            cache_cnt <= 0;
            last_wa   <= '0;
            last_wd   <= '0;
            last_cd   <= '0;
            last_cl   <= '0;
            for (int i = 0; i < 16; i++) bmem[i] <= '0;
        end else begin
            if (mem_req && !mem_ack) mcnt <= mcnt + 2'd1;
            else                     mcnt <= '0;
            if (mem_ack && mem_we) begin
                bmem[mem_addr[3:0]] <= mem_wdata;
                wr_cnt  <= wr_cnt + 1;
                last_wa <= mem_addr;
                last_wd <= mem_wdata;
            end
            if (cache_we) begin
                cache_cnt <= cache_cnt + 1;
                last_cl   <= cache_line;
                last_cd   <= cache_wdata;
            end
        end
    end

    int checks = 0;
    int fails  = 0;

    task automatic check(input logic ok, input string what, input int act, input int exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h", what, act, exp);
        end
    endtask

    task automatic idle(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic cfg(input logic sel, input logic [AW-1:0] v);
        cfg_we = 1'b1; cfg_sel = sel; cfg_wdata = v;
        @(negedge clk);
        cfg_we = 1'b0;
    endtask

    // Issue one CPU request at a falling edge; return cycles waited and read results.
    task automatic do_op(input logic [1:0] m, input logic w, input logic [AW-1:0] a,
                         input logic [DW-1:0] d, input logic h, input logic [LW-1:0] l,
                         output int lat, output logic [DW-1:0] rd, output logic arr);
        mode = m; req_write = w; req_addr = a; req_wdata = d;
        lookup_hit = h; lookup_line = l; req_valid = 1'b1;
        lat = 0; rd = '0; arr = 1'b0;
        forever begin
            #0.5;
            if (cpu_done) begin
                rd = cpu_rdata; arr = cpu_rd_from_array;
                break;
            end
            if (lat > 50) break;
            @(negedge clk);
            lat++;
        end
        @(negedge clk);
        req_valid = 1'b0;
    endtask

    task automatic do_evict(input logic [LW-1:0] l, input logic [AW-1:0] a,
                            input logic [DW-1:0] d, output int lat);
        evict_req = 1'b1; evict_line = l; evict_addr = a; evict_data = d;
        lat = 0;
        forever begin
            #0.5;
            if (evict_done || lat > 50) break;
            @(negedge clk);
            lat++;
        end
        @(negedge clk);
        evict_req = 1'b0;
    endtask

    typedef struct packed {
        logic [1:0]  m;
        logic        w;
        logic [15:0] a;
        logic [15:0] d;
        logic        h;
        logic [2:0]  l;
        logic [3:0]  lat;
        logic [1:0]  cn;
        logic [1:0]  mn;
        logic [15:0] rd;
        logic        arr;
    } vec_t;

    localparam int NV = 13;
    localparam vec_t VECS [NV] = '{
        '{2'd0, 1'b1, 16'h0004, 16'hA1A1, 1'b1, 3'd1, 4'd3, 2'd1, 2'd1, 16'h0000, 1'b0}, // R5
        '{2'd0, 1'b1, 16'h0005, 16'hB2B2, 1'b0, 3'd1, 4'd3, 2'd0, 2'd1, 16'h0000, 1'b0}, // R4
        '{2'd0, 1'b1, 16'h0108, 16'hC3C3, 1'b1, 3'd2, 4'd3, 2'd0, 2'd1, 16'h0000, 1'b0}, // R3
        '{2'd0, 1'b0, 16'h0108, 16'h0000, 1'b1, 3'd2, 4'd3, 2'd0, 2'd0, 16'hC3C3, 1'b0}, // R3
        '{2'd0, 1'b0, 16'h0004, 16'h0000, 1'b1, 3'd1, 4'd0, 2'd0, 2'd0, 16'h0000, 1'b1}, // R13
        '{2'd0, 1'b1, 16'h0110, 16'hD4D4, 1'b1, 3'd4, 4'd3, 2'd1, 2'd1, 16'h0000, 1'b0}, // R2 end
        '{2'd0, 1'b0, 16'h010F, 16'h0000, 1'b1, 3'd0, 4'd3, 2'd0, 2'd0, 16'h0000, 1'b0}, // R2 last
        '{2'd1, 1'b1, 16'h0006, 16'hE5E5, 1'b1, 3'd2, 4'd0, 2'd1, 2'd1, 16'h0000, 1'b0}, // R6
        '{2'd2, 1'b1, 16'h0007, 16'hF6F6, 1'b1, 3'd3, 4'd0, 2'd1, 2'd0, 16'h0000, 1'b0}, // R9
        '{2'd2, 1'b1, 16'h0009, 16'h1717, 1'b0, 3'd3, 4'd3, 2'd0, 2'd1, 16'h0000, 1'b0}, // R4
        '{2'd2, 1'b1, 16'h0100, 16'h2828, 1'b1, 3'd0, 4'd3, 2'd0, 2'd1, 16'h0000, 1'b0}, // R2 R3 base
        '{2'd2, 1'b1, 16'h00FF, 16'h3939, 1'b1, 3'd7, 4'd0, 2'd1, 2'd0, 16'h0000, 1'b0}, // R9
        '{2'd2, 1'b0, 16'h0100, 16'h0000, 1'b1, 3'd0, 4'd3, 2'd0, 2'd0, 16'h2828, 1'b0}  // R3
    };

    initial begin : watchdog
        #(4 * 200000);
        fails++;
        $display("FAIL watchdog expired actual=%0d expected=0", 1);
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

    initial begin : main
        int lat, w0, c0;
        logic [DW-1:0] rd;
        logic arr;

        idle(3);
        rst_n = 1'b1;
        @(negedge clk);
        #0.5;
        // R1 reset state
        check(mem_req == 1'b0,    "R1 mem_req", mem_req, 0);
        check(cpu_done == 1'b0,   "R1 cpu_done", cpu_done, 0);
        check(dirty_mask == '0,   "R1 dirty_mask", dirty_mask, 0);
        check(quiescent == 1'b1,  "R1 quiescent", quiescent, 1);

        cfg(1'b0, 16'h0100);
        cfg(1'b1, 16'h0010);

        // R6 R7 back-to-back posted hits
        w0 = wr_cnt;
        do_op(2'd1, 1'b1, 16'h0020, 16'h1111, 1'b1, 3'd4, lat, rd, arr);
        check(lat == 0, "R6 first posted latency", lat, 0);
        do_op(2'd1, 1'b1, 16'h0021, 16'h2222, 1'b1, 3'd5, lat, rd, arr);
        check(lat == 3, "R7 stalled posted latency", lat, 3);
        idle(6);
        check(wr_cnt - w0 == 2, "R6 drained writes", wr_cnt - w0, 2);
        check(last_wa == 16'h0021 && last_wd == 16'h2222, "R7 last drained addr", last_wa, 16'h0021);

        // R8 R13 forwarding from the occupied buffer
        do_op(2'd1, 1'b1, 16'h0030, 16'hBEEF, 1'b1, 3'd1, lat, rd, arr);
        do_op(2'd1, 1'b0, 16'h0030, 16'h0000, 1'b1, 3'd1, lat, rd, arr);
        check(lat == 0 && arr == 1'b0, "R8 forward latency/source", lat, 0);
        check(rd == 16'hBEEF, "R8 forward data", rd, 16'hBEEF);
        do_op(2'd1, 1'b0, 16'h0031, 16'h0000, 1'b1, 3'd1, lat, rd, arr);
        check(lat == 0 && arr == 1'b1, "R13 non-matching read from array", arr, 1);
        idle(6);

        // R11 miss behind occupied buffer
        w0 = wr_cnt;
        do_op(2'd1, 1'b1, 16'h0040, 16'h4444, 1'b1, 3'd2, lat, rd, arr);
        do_op(2'd1, 1'b1, 16'h0041, 16'h4545, 1'b0, 3'd2, lat, rd, arr);
        check(lat == 6, "R11 miss waits for drain", lat, 6);
        idle(2);
        check(wr_cnt - w0 == 2, "R11 write count", wr_cnt - w0, 2);
        check(last_wa == 16'h0041, "R11 order, later write last", last_wa, 16'h0041);
        check(bmem[0] == 16'h4444, "R11 buffered data in memory", bmem[0], 16'h4444);

        // Table walk
        for (int i = 0; i < NV; i++) begin
            w0 = wr_cnt; c0 = cache_cnt;
            do_op(VECS[i].m, VECS[i].w, VECS[i].a, VECS[i].d, VECS[i].h, VECS[i].l, lat, rd, arr);
            idle(6);
            check(lat == int'(VECS[i].lat), $sformatf("vec %0d latency", i), lat, VECS[i].lat);
            check(cache_cnt - c0 == int'(VECS[i].cn), $sformatf("vec %0d array writes", i),
                  cache_cnt - c0, VECS[i].cn);
            check(wr_cnt - w0 == int'(VECS[i].mn), $sformatf("vec %0d memory writes", i),
                  wr_cnt - w0, VECS[i].mn);
            if (VECS[i].cn != 0)
                check(last_cl == VECS[i].l && last_cd == VECS[i].d,
                      $sformatf("vec %0d array line/data", i), last_cd, VECS[i].d);
            if (VECS[i].mn != 0)
                check(last_wa == VECS[i].a && last_wd == VECS[i].d,
                      $sformatf("vec %0d memory addr/data", i), last_wd, VECS[i].d);
            if (!VECS[i].w)
                check(rd == VECS[i].rd && arr == VECS[i].arr,
                      $sformatf("vec %0d read data/source", i), rd, VECS[i].rd);
        end

        // R9 R12 dirty lines 3 and 7 remain
        check(dirty_mask == 8'h88, "R9 dirty mask", dirty_mask, 8'h88);
        check(quiescent == 1'b0, "R12 not quiescent while dirty", quiescent, 0);

        // R10 evictions
        w0 = wr_cnt;
        do_evict(3'd3, 16'h0007, 16'h5555, lat);
        check(lat == 3, "R10 dirty eviction latency", lat, 3);
        check(wr_cnt - w0 == 1 && last_wa == 16'h0007 && last_wd == 16'h5555,
              "R10 dirty eviction write", last_wd, 16'h5555);
        w0 = wr_cnt;
        do_evict(3'd3, 16'h0007, 16'h5555, lat);
        idle(4);
        check(lat == 0 && wr_cnt == w0, "R10 cleared line evicts silently", wr_cnt - w0, 0);
        do_evict(3'd6, 16'h000A, 16'h6666, lat);
        idle(4);
        check(lat == 0 && wr_cnt == w0, "R10 clean eviction no write", wr_cnt - w0, 0);
        do_evict(3'd7, 16'h00FF, 16'h3939, lat);
        idle(1);
        // R3 uncached write hit on line 0 must not have dirtied it
        check(quiescent == 1'b1, "R12 R3 quiescent after evictions", quiescent, 1);

        // R2 empty window: base address becomes cacheable
        cfg(1'b1, 16'h0000);
        c0 = cache_cnt;
        do_op(2'd2, 1'b1, 16'h0100, 16'h7777, 1'b1, 3'd2, lat, rd, arr);
        idle(1);
        check(lat == 0 && cache_cnt - c0 == 1, "R2 size zero is cacheable", cache_cnt - c0, 1);
        check(dirty_mask == 8'h04, "R2 line dirtied", dirty_mask, 8'h04);

        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

endmodule